// File: doc/BRIEF.md
# Paired Load Decoder and Address Generator

This block decodes a 32-bit instruction word that loads two 64-bit values into two destination registers, and computes the memory address that the load uses. The instruction has three addressing forms. The post-index form reads at the unmodified base and then updates the base. The pre-index form reads at base plus offset and writes that address back. The signed-offset form reads at base plus offset and leaves the base unchanged. The offset is a 7-bit signed immediate scaled by eight.

The block is given the instruction word, the value of the general register that the base field names, and the stack pointer value. It reports the two destination indices, the base index, the access address, the write-back value and its enable, and the flags for undefined, no-op, unknown-result and no-match cases. It also reports a stack-pointer misalignment and a tag-check request. Two static parameters choose how the two unpredictable register-overlap cases are resolved. The register file, the memory access and the privilege handling live outside the block.

Top module: `pair_load_decoder`

## Requirements
- R1: A word matches only when bits [31:30]=11, [29:27]=101, [26]=0, [22]=1 and [25:23] is 001 (post-index), 011 (pre-index) or 010 (signed offset). Any other word sets `nomatch_o` and holds `ld_en_o`, `wb_en_o`, `undef_o` and `nop_o` low.
- R2: The first destination index comes from bits [4:0], the second destination from [14:10] and the base from [9:5]. The immediate is in [21:15].
- R3: The byte offset is the immediate sign-extended to 64 bits and shifted left by 2 plus bit 31. For this encoding that is a shift of 3.
- R4: Signed-offset and pre-index forms access base+offset. The post-index form accesses the base. Both write-back forms set `wb_en_o` with `wb_val_o` = base+offset. The signed-offset form leaves `wb_en_o` low.
- R5: A base index of 31 takes the base from `sp_val_i` and sets `use_sp_o`. `sp_align_fault_o` is set when the load proceeds from the stack pointer and the low 4 bits of the stack pointer are not zero.
- R6: A matching word with `feat_en_i` low sets `undef_o` and holds `ld_en_o` and `wb_en_o` low.
- R7: An overlap occurs when write-back is requested, the base is not 31 and the base equals either destination. With the default resolution, write-back is suppressed: `wb_en_o` stays low and `ld_en_o` stays high. A base of 31 is never an overlap.
- R8: Equal destination indices, with the default resolution, set `undef_o` and hold `ld_en_o` low. The overlap check is applied before this check.
- R9: When the load proceeds, `tag_check_o` is high if the form requests write-back or if the base is not 31. Otherwise it is low.
- R10: `valid_o` is high exactly one cycle after a `valid_i` cycle. All other outputs are captured on that `valid_i` cycle and are held until the next one. After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word and operands are valid |
| feat_en_i | input | 1 | Enables recognition of the instruction |
| insn_i | input | 32 | Instruction word |
| xn_val_i | input | 64 | Value of the general register named by the base field |
| sp_val_i | input | 64 | Stack pointer value |
| valid_o | output | 1 | Results are valid this cycle |
| nomatch_o | output | 1 | Word is not this instruction |
| undef_o | output | 1 | Instruction is undefined |
| nop_o | output | 1 | Instruction is treated as a no-op |
| ld_en_o | output | 1 | Load proceeds and both destinations are written |
| rt1_o | output | 5 | First destination index |
| rt2_o | output | 5 | Second destination index |
| rn_o | output | 5 | Base index |
| use_sp_o | output | 1 | Base is the stack pointer |
| addr_o | output | 64 | Access address |
| wb_en_o | output | 1 | Base write-back enable |
| wb_val_o | output | 64 | Base write-back value (zero when unknown) |
| wb_unknown_o | output | 1 | Write-back value is unknown |
| rt_unknown_o | output | 1 | Loaded values are unknown |
| sp_align_fault_o | output | 1 | Stack pointer alignment check failed |
| tag_check_o | output | 1 | Access requires a tag check |

## Verification
All decode and address logic is combinational, and it feeds a single output register stage. Every result is therefore due in the cycle after the `valid_i` cycle, when `valid_o` is high. The bench drives each word on a falling edge and drops `valid_i` on the next falling edge. It then reads every output at that falling edge, half a cycle after the capturing rising edge. One extra idle cycle is used to confirm that `valid_o` falls while the captured address and enables stay unchanged.

// File: rtl/pld_pkg.sv
package pld_pkg;
  localparam int unsigned INSN_W = 32;
  localparam int unsigned REG_W  = 5;
  localparam int unsigned IMM_W  = 7;

  typedef enum logic [1:0] {OVL_SUPPRESS, OVL_UNKNOWN, OVL_UNDEF, OVL_NOP} ovl_res_e;
  typedef enum logic [1:0] {DUP_UNKNOWN, DUP_UNDEF, DUP_NOP} dup_res_e;
  typedef enum logic [1:0] {FORM_NONE, FORM_POST, FORM_PRE, FORM_OFF} form_e;

  typedef struct packed {
    logic             match;
    form_e            form;
    logic [REG_W-1:0] rt1;
    logic [REG_W-1:0] rt2;
    logic [REG_W-1:0] rn;
    logic [IMM_W-1:0] imm;
    logic             scale_hi;
  } dec_t;
endpackage

// File: rtl/pld_decode.sv
module pld_decode
  import pld_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  output dec_t              dec_o
);
  logic fixed_ok;

  assign fixed_ok = (insn_i[31:30] == 2'b11) && (insn_i[29:27] == 3'b101) &&
                    !insn_i[26] && insn_i[22];

  always_comb begin
    dec_o.form = FORM_NONE;
    unique case (insn_i[25:23])
      3'b001:  dec_o.form = FORM_POST;
      3'b011:  dec_o.form = FORM_PRE;
      3'b010:  dec_o.form = FORM_OFF;
      default: dec_o.form = FORM_NONE;
    endcase
    dec_o.match    = fixed_ok && (dec_o.form != FORM_NONE);
    dec_o.imm      = insn_i[21:15];
    dec_o.rt2      = insn_i[14:10];
    dec_o.rn       = insn_i[9:5];
    dec_o.rt1      = insn_i[4:0];
    dec_o.scale_hi = insn_i[31];
  end
endmodule

// File: rtl/pld_agen.sv
module pld_agen
  import pld_pkg::*;
#(
  parameter int unsigned XLEN     = 64,
  parameter int unsigned SP_ALIGN = 4
) (
  input  logic [IMM_W-1:0] imm_i,
  input  logic             scale_hi_i,
  input  form_e            form_i,
  input  logic             use_sp_i,
  input  logic [XLEN-1:0]  xn_i,
  input  logic [XLEN-1:0]  sp_i,
  output logic [XLEN-1:0]  addr_o,
  output logic [XLEN-1:0]  wb_addr_o,
  output logic             misalign_o
);
  localparam int unsigned EXT_W = XLEN - IMM_W;

  logic [XLEN-1:0] base, off_ext, offset, sum;

  assign base    = use_sp_i ? sp_i : xn_i;
  assign off_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
  // scale is 2 + bit 31 of the word
  assign offset  = scale_hi_i ? (off_ext << 3) : (off_ext << 2);
  assign sum     = base + offset;

  assign addr_o     = (form_i == FORM_POST) ? base : sum;
  assign wb_addr_o  = sum;
  assign misalign_o = use_sp_i && (|sp_i[SP_ALIGN-1:0]);
endmodule

// File: rtl/pld_hazard.sv
module pld_hazard
  import pld_pkg::*;
#(
  parameter ovl_res_e OVL_RES = OVL_SUPPRESS,
  parameter dup_res_e DUP_RES = DUP_UNDEF
) (
  input  logic             match_i,
  input  logic             feat_en_i,
  input  logic             wb_req_i,
  input  logic [REG_W-1:0] rt1_i,
  input  logic [REG_W-1:0] rt2_i,
  input  logic [REG_W-1:0] rn_i,
  output logic             undef_o,
  output logic             nop_o,
  output logic             ld_en_o,
  output logic             wb_en_o,
  output logic             wb_unknown_o,
  output logic             rt_unknown_o
);
  logic ovl, dup, wb_keep, wbu, rtu, und, nop;

  assign ovl = wb_req_i && (rn_i != '1) && ((rn_i == rt1_i) || (rn_i == rt2_i));
  assign dup = (rt1_i == rt2_i);

  // overlap resolution first, duplicate-destination resolution second
  always_comb begin
    und     = 1'b0;
    nop     = 1'b0;
    wb_keep = wb_req_i;
    wbu     = 1'b0;
    rtu     = 1'b0;
    if (match_i && !feat_en_i) begin
      und = 1'b1;
    end else if (match_i) begin
      if (ovl) begin
        case (OVL_RES)
          OVL_SUPPRESS: wb_keep = 1'b0;
          OVL_UNKNOWN:  wbu     = 1'b1;
          OVL_UNDEF:    und     = 1'b1;
          default:      nop     = 1'b1;
        endcase
      end
      if (dup && !und && !nop) begin
        case (DUP_RES)
          DUP_UNKNOWN: rtu = 1'b1;
          DUP_UNDEF:   und = 1'b1;
          default:     nop = 1'b1;
        endcase
      end
    end
  end

  assign undef_o      = und;
  assign nop_o        = nop;
  assign ld_en_o      = match_i && !und && !nop;
  assign wb_en_o      = ld_en_o && wb_keep;
  assign wb_unknown_o = ld_en_o && wbu;
  assign rt_unknown_o = ld_en_o && rtu;
endmodule

// File: rtl/pair_load_decoder.sv
module pair_load_decoder
  import pld_pkg::*;
#(
  parameter int unsigned XLEN     = 64,
  parameter int unsigned SP_ALIGN = 4,
  parameter ovl_res_e    OVL_RES  = OVL_SUPPRESS,
  parameter dup_res_e    DUP_RES  = DUP_UNDEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              feat_en_i,
  input  logic [INSN_W-1:0] insn_i,
  input  logic [XLEN-1:0]   xn_val_i,
  input  logic [XLEN-1:0]   sp_val_i,
  output logic              valid_o,
  output logic              nomatch_o,
  output logic              undef_o,
  output logic              nop_o,
  output logic              ld_en_o,
  output logic [REG_W-1:0]  rt1_o,
  output logic [REG_W-1:0]  rt2_o,
  output logic [REG_W-1:0]  rn_o,
  output logic              use_sp_o,
  output logic [XLEN-1:0]   addr_o,
  output logic              wb_en_o,
  output logic [XLEN-1:0]   wb_val_o,
  output logic              wb_unknown_o,
  output logic              rt_unknown_o,
  output logic              sp_align_fault_o,
  output logic              tag_check_o
);
  dec_t            dec;
  logic            use_sp, wb_req, misalign;
  logic            h_undef, h_nop, h_ld, h_wb, h_wbu, h_rtu;
  logic [XLEN-1:0] addr, wb_addr;

  pld_decode u_dec (.insn_i(insn_i), .dec_o(dec));

  assign use_sp = (dec.rn == '1);
  assign wb_req = dec.match && ((dec.form == FORM_POST) || (dec.form == FORM_PRE));

  pld_agen #(.XLEN(XLEN), .SP_ALIGN(SP_ALIGN)) u_agen (
    .imm_i(dec.imm), .scale_hi_i(dec.scale_hi), .form_i(dec.form),
    .use_sp_i(use_sp), .xn_i(xn_val_i), .sp_i(sp_val_i),
    .addr_o(addr), .wb_addr_o(wb_addr), .misalign_o(misalign)
  );

  pld_hazard #(.OVL_RES(OVL_RES), .DUP_RES(DUP_RES)) u_haz (
    .match_i(dec.match), .feat_en_i(feat_en_i), .wb_req_i(wb_req),
    .rt1_i(dec.rt1), .rt2_i(dec.rt2), .rn_i(dec.rn),
    .undef_o(h_undef), .nop_o(h_nop), .ld_en_o(h_ld), .wb_en_o(h_wb),
    .wb_unknown_o(h_wbu), .rt_unknown_o(h_rtu)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o          <= 1'b0;
      nomatch_o        <= 1'b0;
      undef_o          <= 1'b0;
      nop_o            <= 1'b0;
      ld_en_o          <= 1'b0;
      rt1_o            <= '0;
      rt2_o            <= '0;
      rn_o             <= '0;
      use_sp_o         <= 1'b0;
      addr_o           <= '0;
      wb_en_o          <= 1'b0;
      wb_val_o         <= '0;
      wb_unknown_o     <= 1'b0;
      rt_unknown_o     <= 1'b0;
      sp_align_fault_o <= 1'b0;
      tag_check_o      <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        nomatch_o        <= !dec.match;
        undef_o          <= h_undef;
        nop_o            <= h_nop;
        ld_en_o          <= h_ld;
        rt1_o            <= dec.rt1;
        rt2_o            <= dec.rt2;
        rn_o             <= dec.rn;
        use_sp_o         <= use_sp;
        addr_o           <= addr;
        wb_en_o          <= h_wb;
        wb_val_o         <= h_wbu ? '0 : wb_addr;
        wb_unknown_o     <= h_wbu;
        rt_unknown_o     <= h_rtu;
        sp_align_fault_o <= h_ld && misalign;
        tag_check_o      <= h_ld && (wb_req || !use_sp);
      end
    end
  end

  a_r10_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));
  a_r1_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $onehot0({nomatch_o, undef_o, nop_o, ld_en_o}));
  a_r1_wb_needs_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> ld_en_o);
  a_r7_no_overlap_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && wb_en_o && !use_sp_o && (OVL_RES != OVL_UNKNOWN))
      |-> (rn_o != rt1_o) && (rn_o != rt2_o));
  a_r8_distinct_dest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ld_en_o && !rt_unknown_o) |-> (rt1_o != rt2_o));
  a_r9_tag_on_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ld_en_o && (wb_en_o || !use_sp_o)) |-> tag_check_o);
  a_r5_fault_on_sp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_align_fault_o |-> use_sp_o && ld_en_o);
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i) |-> $stable(addr_o) && $stable(ld_en_o) && $stable(wb_en_o));
endmodule

// File: tb/sim_pair_load_decoder.sv
module sim_pair_load_decoder;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        valid_i = 1'b0, feat_en = 1'b1;
  logic [31:0] insn = '0;
  logic [63:0] xn = '0, sp = '0;
  logic        valid_o, nomatch, undef, nop, ld_en, use_sp, wb_en, wb_unk, rt_unk, sp_flt, tag;
  logic [4:0]  rt1, rt2, rn;
  logic [63:0] addr, wb_val;
  int checks = 0, fails = 0;

  localparam logic [2:0] F_POST = 3'b001, F_PRE = 3'b011, F_OFF = 3'b010;

  always #5 clk = ~clk;

  pair_load_decoder u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .feat_en_i(feat_en), .insn_i(insn),
    .xn_val_i(xn), .sp_val_i(sp), .valid_o(valid_o), .nomatch_o(nomatch), .undef_o(undef),
    .nop_o(nop), .ld_en_o(ld_en), .rt1_o(rt1), .rt2_o(rt2), .rn_o(rn), .use_sp_o(use_sp),
    .addr_o(addr), .wb_en_o(wb_en), .wb_val_o(wb_val), .wb_unknown_o(wb_unk),
    .rt_unknown_o(rt_unk), .sp_align_fault_o(sp_flt), .tag_check_o(tag)
  );

  function automatic logic [31:0] enc(input logic [2:0] f, input logic [6:0] imm,
                                      input logic [4:0] t2, input logic [4:0] n,
                                      input logic [4:0] t);
    return {2'b11, 3'b101, 1'b0, f, 1'b1, imm, t2, n, t};
  endfunction

  function automatic logic [63:0] off(input logic [6:0] imm);
    return {{57{imm[6]}}, imm} << 3;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive on falling edge, capture on rising edge, sample at next falling edge
  task automatic issue(input logic [31:0] w, input logic [63:0] x, input logic [63:0] s,
                       input logic fe);
    @(negedge clk);
    insn = w; xn = x; sp = s; feat_en = fe; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    chk("R10 valid_o", {63'd0, valid_o}, 64'd1);
  endtask

  task automatic t_reset();
    chk("R10 reset valid", {63'd0, valid_o}, 64'd0);
    chk("R10 reset ld_en", {63'd0, ld_en}, 64'd0);
    chk("R10 reset addr", addr, 64'd0);
  endtask

  task automatic t_offset();
    issue(enc(F_OFF, 7'd5, 5'd7, 5'd3, 5'd2), 64'h1000, 64'h0, 1'b1);
    chk("R2 rt1", {59'd0, rt1}, 64'd2);
    chk("R2 rt2", {59'd0, rt2}, 64'd7);
    chk("R2 rn", {59'd0, rn}, 64'd3);
    chk("R3 R4 offset addr", addr, 64'h1000 + off(7'd5));
    chk("R4 offset no wb", {63'd0, wb_en}, 64'd0);
    chk("R1 ld_en", {63'd0, ld_en}, 64'd1);
    chk("R9 tag base not 31", {63'd0, tag}, 64'd1);
    @(negedge clk);
    chk("R10 valid drops", {63'd0, valid_o}, 64'd0);
    chk("R10 addr held", addr, 64'h1000 + off(7'd5));
  endtask

  task automatic t_pre_neg();
    issue(enc(F_PRE, 7'h7f, 5'd1, 5'd4, 5'd6), 64'h2000, 64'h0, 1'b1);
    chk("R3 R4 pre addr", addr, 64'h1ff8);
    chk("R4 pre wb_en", {63'd0, wb_en}, 64'd1);
    chk("R4 pre wb_val", wb_val, 64'h1ff8);
  endtask

  task automatic t_post();
    issue(enc(F_POST, 7'h40, 5'd9, 5'd8, 5'd10), 64'h8000, 64'h0, 1'b1);
    chk("R4 post addr", addr, 64'h8000);
    chk("R3 R4 post wb_val", wb_val, 64'h8000 + off(7'h40));
    chk("R4 post wb_en", {63'd0, wb_en}, 64'd1);
  endtask

  task automatic t_sp();
    issue(enc(F_OFF, 7'd2, 5'd1, 5'd31, 5'd0), 64'h5555, 64'h4000, 1'b1);
    chk("R5 use_sp", {63'd0, use_sp}, 64'd1);
    chk("R5 sp addr", addr, 64'h4010);
    chk("R5 aligned", {63'd0, sp_flt}, 64'd0);
    chk("R9 no tag sp offset", {63'd0, tag}, 64'd0);
    issue(enc(F_PRE, 7'd1, 5'd1, 5'd31, 5'd31), 64'h0, 64'h4008, 1'b1);
    chk("R5 misaligned", {63'd0, sp_flt}, 64'd1);
    chk("R9 tag sp pre", {63'd0, tag}, 64'd1);
    chk("R7 sp not overlap wb_en", {63'd0, wb_en}, 64'd1);
  endtask

  task automatic t_nomatch();
    issue(enc(F_OFF, 7'd1, 5'd1, 5'd2, 5'd3) | 32'h0400_0000, 64'h10, 64'h0, 1'b1);
    chk("R1 bit26 nomatch", {63'd0, nomatch}, 64'd1);
    chk("R1 bit26 ld_en", {63'd0, ld_en}, 64'd0);
    issue(enc(3'b000, 7'd1, 5'd1, 5'd2, 5'd3), 64'h10, 64'h0, 1'b1);
    chk("R1 form000 nomatch", {63'd0, nomatch}, 64'd1);
    chk("R1 form000 wb_en", {63'd0, wb_en}, 64'd0);
    chk("R1 form000 undef", {63'd0, undef}, 64'd0);
  endtask

  task automatic t_feat();
    issue(enc(F_PRE, 7'd1, 5'd1, 5'd2, 5'd3), 64'h10, 64'h0, 1'b0);
    chk("R6 undef", {63'd0, undef}, 64'd1);
    chk("R6 ld_en", {63'd0, ld_en}, 64'd0);
    chk("R6 wb_en", {63'd0, wb_en}, 64'd0);
    chk("R6 nomatch", {63'd0, nomatch}, 64'd0);
  endtask

  task automatic t_overlap();
    issue(enc(F_PRE, 7'd1, 5'd5, 5'd3, 5'd3), 64'h100, 64'h0, 1'b1);
    chk("R7 overlap ld_en", {63'd0, ld_en}, 64'd1);
    chk("R7 overlap wb_en", {63'd0, wb_en}, 64'd0);
    chk("R7 overlap undef", {63'd0, undef}, 64'd0);
    issue(enc(F_POST, 7'd1, 5'd3, 5'd3, 5'd5), 64'h100, 64'h0, 1'b1);
    chk("R7 overlap rt2 wb_en", {63'd0, wb_en}, 64'd0);
    chk("R9 tag after suppress", {63'd0, tag}, 64'd1);
  endtask

  task automatic t_dup();
    issue(enc(F_OFF, 7'd1, 5'd4, 5'd2, 5'd4), 64'h100, 64'h0, 1'b1);
    chk("R8 dup undef", {63'd0, undef}, 64'd1);
    chk("R8 dup ld_en", {63'd0, ld_en}, 64'd0);
    issue(enc(F_PRE, 7'd1, 5'd4, 5'd4, 5'd4), 64'h100, 64'h0, 1'b1);
    chk("R8 overlap then dup undef", {63'd0, undef}, 64'd1);
    chk("R8 overlap then dup wb_en", {63'd0, wb_en}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_offset();
    t_pre_neg();
    t_post();
    t_sp();
    t_nomatch();
    t_feat();
    t_overlap();
    t_dup();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule